// File: doc/BRIEF.md
# Per-Hart Machine Timer Comparator

This block gives every hart of a cluster a machine-level timer interrupt. One free-running 64-bit time count is shared by all harts. Each hart has its own 64-bit compare register. A hart's interrupt line is high whenever its compare value is not greater than the current time. Software on any hart reaches the registers through a simple 32-bit register port, which has valid, write, byte address and data signals. Every 64-bit quantity is split into two 32-bit words, and each word is read or written alone.

The register window is 0x8000 bytes and is little-endian. The compare registers form an array that starts at offset zero. The time count sits in the last eight bytes of the window and can only be read. The time count advances by one on each cycle of a tick-enable input. That input is a strobe from the time-base generator, for example 10 MHz. Software arms a hart by writing a future compare value, which clears that hart's interrupt. The interrupt rises again once the count reaches the compare value.

Top module: `hart_timer_cmp`

## Requirements
- R1: Hart i's compare register has its low word at byte offset 8*i and its high word at 8*i+4. A write to one word replaces only that word and keeps the other. A read returns the word last written.
- R2: The time count is read at offset 0x7FF8 (bits 31:0) and 0x7FFC (bits 63:32). Writes to either offset have no effect on the count.
- R3: The time count is zero after reset. It increases by exactly one on each clock edge where tick_en is high and holds otherwise.
- R4: On the clock edge after a change, irq_o[i] shows whether compare register i is less than or equal to the time count, unsigned over 64 bits. This covers a compare value written in the past, which raises the line at once.
- R5: Writing a compare value greater than the time count drops that hart's line. The line stays low until the count reaches the value.
- R6: Compare registers reset to zero. irq_o is low while rst_n is low and rises on the first edge after release, because 0 <= 0.
- R7: A compare slot index (offset bits 14:3) at or above NUM_HARTS reads as zero, and writes to it change nothing.
- R8: Any access with offset bits 1:0 not zero reads as zero and does not change any register.
- R9: Read data appears on rsp_rdata on the clock edge after a read request and holds until the next read. rsp_rdata is zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Time-base strobe; the count advances once per high cycle |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
A corrupted compare word or a stuck time bit shows on irq_o within one clock of the stimulus that should move it. It also shows on rsp_rdata one clock after a read of that word. A decode fault that lets a write reach a time word, an out-of-range slot or an unaligned offset leaves a trace in two places. The lines of the other harts flip, or a later read-back of the neighbouring compare words differs. The bench therefore follows every such write with an interrupt check and a read-back. It holds tick_en low between its own tick bursts, so every count read has an exact expected value.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int WIN_AW    = 15;
  localparam int SLOT_W    = 12;
  localparam int TIME_W    = 64;
  localparam int WORD_W    = 32;
  localparam int MAX_HARTS = 4095;
  localparam logic [WIN_AW-1:0] TIME_LO_OFF = 15'h7FF8;
  localparam logic [WIN_AW-1:0] TIME_HI_OFF = 15'h7FFC;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CMP  = 2'd1,
    RG_TIME = 2'd2
  } region_e;

  typedef struct packed {
    region_e           rg;
    logic              hi;
    logic [SLOT_W-1:0] slot;
  } dec_t;
endpackage

// File: rtl/mtc_addr_dec.sv
module mtc_addr_dec
  import mtc_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic [WIN_AW-1:0] addr,
  output dec_t              dec
);
  logic aligned;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    dec.slot = addr[WIN_AW-1:3];
    dec.hi   = addr[2];
    dec.rg   = RG_NONE;
    if (aligned && (addr == TIME_LO_OFF || addr == TIME_HI_OFF)) begin
      dec.rg = RG_TIME;
    end else if (aligned && (addr[WIN_AW-1:3] < SLOT_W'(NUM_HARTS))) begin
      dec.rg = RG_CMP;
    end
  end
endmodule

// File: rtl/mtc_time_ctr.sv
module mtc_time_ctr
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  output logic [TIME_W-1:0] time_q
);
  logic [TIME_W-1:0] time_d;

  always_comb begin
    time_d = time_q + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (tick_en) begin
      time_q <= time_d;
    end
  end
endmodule

// File: rtl/mtc_cmp_bank.sv
module mtc_cmp_bank
  import mtc_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [SLOT_W-1:0]                   wr_slot,
  input  logic                                wr_hi,
  input  logic [WORD_W-1:0]                   wr_data,
  output logic [NUM_HARTS-1:0][TIME_W-1:0]    cmp_q
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic              hit;
    logic [TIME_W-1:0] val_q;
    logic [TIME_W-1:0] val_d;

    always_comb begin
      hit   = wr_en && (wr_slot == SLOT_W'(h));
      val_d = val_q;
      if (wr_hi) begin
        val_d[TIME_W-1:WORD_W] = wr_data;
      end else begin
        val_d[WORD_W-1:0] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= val_d;
      end
    end

    assign cmp_q[h] = val_q;
  end
endmodule

// File: rtl/mtc_irq_gen.sv
module mtc_irq_gen
  import mtc_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_q,
  input  logic [TIME_W-1:0]                time_q,
  output logic [NUM_HARTS-1:0]             irq_q
);
  logic [NUM_HARTS-1:0] irq_d;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_cmp
    always_comb begin
      irq_d[h] = (cmp_q[h] <= time_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp
  import mtc_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [14:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  dec_t                             dec;
  logic [TIME_W-1:0]                time_q;
  logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_q;
  logic                             cmp_wr;
  logic                             rd_en;
  logic [TIME_W-1:0]                cmp_sel;
  logic [WORD_W-1:0]                rd_word;
  logic [WORD_W-1:0]                rdata_d;
  logic [WORD_W-1:0]                rdata_q;

  initial begin
    if (NUM_HARTS < 1 || NUM_HARTS > MAX_HARTS) begin
      $error("NUM_HARTS out of range");
    end
  end

  mtc_addr_dec #(.NUM_HARTS(NUM_HARTS)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  mtc_time_ctr u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .time_q  (time_q)
  );

  mtc_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmp_wr),
    .wr_slot (dec.slot),
    .wr_hi   (dec.hi),
    .wr_data (req_wdata),
    .cmp_q   (cmp_q)
  );

  mtc_irq_gen #(.NUM_HARTS(NUM_HARTS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_q  (cmp_q),
    .time_q (time_q),
    .irq_q  (irq_o)
  );

  always_comb begin
    cmp_wr  = req_valid && req_write && (dec.rg == RG_CMP);
    rd_en   = req_valid && !req_write;
    cmp_sel = cmp_q[dec.slot[IDX_W-1:0]];
    case (dec.rg)
      RG_CMP:  rd_word = dec.hi ? cmp_sel[TIME_W-1:WORD_W] : cmp_sel[WORD_W-1:0];
      RG_TIME: rd_word = dec.hi ? time_q[TIME_W-1:WORD_W] : time_q[WORD_W-1:0];
      default: rd_word = '0;
    endcase
    rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker
  import mtc_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             tick_en,
  input logic                             req_valid,
  input logic                             req_write,
  input logic [14:0]                      req_addr,
  input logic [31:0]                      rsp_rdata,
  input logic [NUM_HARTS-1:0]             irq_o,
  input logic [TIME_W-1:0]                time_q,
  input logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_q
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  // R3, R2: the count moves only by the tick, whatever the bus does
  a_r3_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> time_q == $past(time_q) + TIME_W'($past(tick_en)));

  // R4: interrupt level follows the comparison one edge later
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_lvl
    a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> irq_o[h] == ($past(cmp_q[h]) <= $past(time_q)));
  end

  // R1, R7, R8: compare words change only under a write request
  a_r1_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(cmp_q));

  // R2, R9: time low word read returns the count seen at the request
  a_r2_time_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == TIME_LO_OFF) |=>
      rsp_rdata == $past(time_q[WORD_W-1:0]));

  // R8: unaligned reads return zero
  a_r8_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[1:0] != 2'b00) |=> rsp_rdata == '0);
endmodule

bind hart_timer_cmp mtc_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .irq_o     (irq_o),
  .time_q    (time_q),
  .cmp_q     (cmp_q)
);

// File: tb/hart_timer_cmp_test.sv
module hart_timer_cmp_test;
  localparam int NH = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en;
  logic          req_valid;
  logic          req_write;
  logic [14:0]   req_addr;
  logic [31:0]   req_wdata;
  logic [31:0]   rsp_rdata;
  logic [NH-1:0] irq_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  logic  rd_seen;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  hart_timer_cmp #(.NUM_HARTS(NH)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .irq_o     (irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic [NH-1:0] exp, input string tag);
    @(negedge clk);
    check(32'(irq_o), 32'(exp), tag);
  endtask

  // monitor: a read accepted at an edge is compared at the following low phase
  always @(posedge clk) rd_seen <= rst_n && req_valid && !req_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(rsp_rdata, 32'hxxxx_xxxx, "scoreboard empty");
      end else begin
        check(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(32'(irq_o), 32'h0, "R6 irq low in reset");
    check(rsp_rdata, 32'h0, "R9 rdata zero in reset");
    rst_n = 1'b1;
    chk_irq(4'b1111, "R6 all lines up after reset");
    rd(15'h0000, 32'h0, "R6 cmp0 low resets zero");
    rd(15'h001C, 32'h0, "R6 cmp3 high resets zero");

    // arm harts 0..2 in the future or past of time 0
    wr(15'h0000, 32'h10);
    wr(15'h000C, 32'h1);
    wr(15'h0010, 32'h3);
    chk_irq(4'b1000, "R5 future values drop lines");
    wr(15'h0008, 32'hAB);
    rd(15'h000C, 32'h1, "R1 high word kept");
    rd(15'h0008, 32'hAB, "R1 low word written");
    rd(15'h0010, 32'h3, "R1 hart2 low word");

    tick(3);
    chk_irq(4'b1100, "R4 hart2 fires at time 3");
    rd(15'h7FF8, 32'd3, "R3 time low after 3 ticks");
    rd(15'h7FFC, 32'd0, "R2 time high word");
    wr(15'h7FF8, 32'hFFFF_FFFF);
    wr(15'h7FFC, 32'h5);
    rd(15'h7FF8, 32'd3, "R2 time low write ignored");
    rd(15'h7FFC, 32'd0, "R2 time high write ignored");

    tick(12);
    chk_irq(4'b1100, "R5 hart0 low at time 15");
    tick(1);
    chk_irq(4'b1101, "R5 hart0 fires at time 16");

    wr(15'h0018, 32'h100);
    chk_irq(4'b0101, "R5 hart3 future drops line");
    wr(15'h0018, 32'h5);
    chk_irq(4'b1101, "R4 past value raises at once");

    wr(15'h0020, 32'hDEAD);
    rd(15'h0020, 32'h0, "R7 slot 4 low reads zero");
    rd(15'h0024, 32'h0, "R7 slot 4 high reads zero");
    rd(15'h7FF0, 32'h0, "R7 top slot reads zero");
    chk_irq(4'b1101, "R7 out-of-range write no effect");

    wr(15'h0001, 32'hFFFF);
    wr(15'h001A, 32'h0);
    chk_irq(4'b1101, "R8 unaligned writes no effect");
    rd(15'h0000, 32'h10, "R8 cmp0 low unchanged");
    rd(15'h0005, 32'h0, "R8 unaligned read zero");

    rd(15'h0018, 32'h5, "R9 read data");
    repeat (3) @(negedge clk);
    check(rsp_rdata, 32'h5, "R9 read data holds");

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule